// File: doc/BRIEF.md
# Ambient Light Sensor I2C Register Target

This block is the host-facing side of an ambient light sensor: an I2C target that responds at a fixed 7-bit address and holds a small register file. It runs on the system clock. The SCL and SDA pins are oversampled through a synchroniser and a majority-vote filter. The block drives one open-drain enable for SDA, where 1 pulls the line low.

The host writes a register-address byte and then writes or reads one or more bytes. After each byte, a pointer moves on through the implemented registers: 0x00, 0x01, 0x02, 0x03, 0x0F, and then back to 0x00.

- Two command registers select the measurement mode, the converter resolution and the lux range. Their fields drive output ports that go to the converter.
- Two read-only registers hold the latest 16-bit conversion result. This result is loaded from a sideband port.
- One status register combines a fixed identity code with a brownout flag. The flag is set at reset and only the host can clear it.

A STOP that arrives before a byte and its acknowledge have finished discards that byte.

Top module: `lightsense_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal 1000100 is acknowledged, and bit 0 selects the direction (1 read, 0 write). Any other address is not acknowledged, and the target ignores the bus until the next START.
- R2: In a write, the target acknowledges the register-address byte and every data byte, including data bytes aimed at read-only or unimplemented registers.
- R3: Register 0x00 stores the mode in bits 7:5 and drives `mode_o`. Register 0x01 stores resolution in bits 3:2 and range in bits 1:0, driving `res_o` and `range_o`. All other bits of these registers read as 0.
- R4: A cycle with `sample_vld_i` high loads `sample_i` into the data registers. Register 0x02 reads bits 7:0 and register 0x03 reads bits 15:8. Host writes to 0x02 and 0x03 change nothing.
- R5: Register 0x0F reads as {flag, 0, 101, 000}, where the flag is bit 7. Writing a byte with bit 7 = 0 clears the flag. Writing bit 7 = 1 leaves it unchanged. No other bit is writable.
- R6: After reset, registers 0x00 to 0x03 read 0x00, register 0x0F reads 0xA8, the mode, resolution and range outputs are 0, and SDA is released.
- R7: After each byte written or read, the pointer moves as follows:
  - from 0x00, 0x01 or 0x02 it goes to the next address;
  - from 0x03 to 0x0E it goes to 0x0F;
  - from 0x0F upward it goes to 0x00.
  Unimplemented addresses read as 0x00.
- R8: A read is a write of the register address, then a repeated START with the read bit set. Data is sent MSB first. A host ACK requests the next byte, and a host NACK ends the read and releases SDA.
- R9: A STOP that arrives while a data byte is still being shifted in leaves every register unchanged. A write is committed only at the end of its acknowledge clock.
- R10: The SDA drive enable changes only while the filtered SCL is low. The only exceptions are the releases forced by a START or a STOP.
- R11: A low pulse on SCL that lasts one clock cycle, during an SCL high phase, is rejected by the filter. It does not shift a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock pin level |
| sda_i | input | 1 | I2C data pin level |
| sda_oe_o | output | 1 | Open-drain SDA enable, 1 pulls the line low |
| sample_i | input | 16 | Conversion result from the converter |
| sample_vld_i | input | 1 | Loads `sample_i` into the data registers |
| mode_o | output | 3 | Operation mode field |
| res_o | output | 2 | Resolution field |
| range_o | output | 2 | Range field |

## Verification
- **Field sweep:** the command registers receive a sweep of spaced byte values through burst writes and are read back, so any misplaced, unmasked or stuck field bit is exposed.
- **Pointer order:** burst writes and burst reads start at 0x03, 0x0F, 0x07 and 0x20. Comparing the returned byte order against the expected sequence separates a plain incrementing pointer from one that skips the gap and wraps.
- **Abort, mismatch and flag:** STOPs placed after four and seven data bits, and a non-matching address followed by data, tell apart a design that commits too early from one that commits correctly. Writes of bit 7 = 1 and bit 7 = 0 to 0x0F tell apart a write-zero-to-clear flag from a plain storage bit.
- **Glitch rejection:** a one-cycle SCL dropout inside a data bit checks that the filter rejects single-sample glitches.

// File: rtl/lsens_pkg.sv
package lsens_pkg;

    localparam logic [7:0] A_MODE = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h01;
    localparam logic [7:0] A_DLO  = 8'h02;
    localparam logic [7:0] A_DHI  = 8'h03;
    localparam logic [7:0] A_IDST = 8'h0F;

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK} xfer_st_e;
    typedef enum logic [1:0] {PH_DEV, PH_REG, PH_WR} rx_ph_e;

    // Pointer walk over the sparse map: 00,01,02,03,0F,00...
    function automatic logic [7:0] ptr_next(input logic [7:0] p);
        if (p < A_DHI)
            ptr_next = p + 8'd1;
        else if (p < A_IDST)
            ptr_next = A_IDST;
        else
            ptr_next = A_MODE;
    endfunction

endpackage

// File: rtl/lsens_line_filter.sv
module lsens_line_filter #(
    parameter int   SYNC_DEPTH = 2,
    parameter int   VOTES      = 3,
    parameter logic IDLE_LVL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int MAJ = VOTES / 2 + 1;

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] sync;
        logic [VOTES-1:0]      win;
        logic                  out;
    } flt_t;

    flt_t q, d;
    int   ones;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_DEPTH-2:0], line_i};
        d.win  = {q.win[VOTES-2:0], q.sync[SYNC_DEPTH-1]};
        ones   = 0;
        for (int i = 0; i < VOTES; i++) begin
            ones = ones + int'(q.win[i]);
        end
        d.out = (ones >= MAJ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= {SYNC_DEPTH{IDLE_LVL}};
            q.win  <= {VOTES{IDLE_LVL}};
            q.out  <= IDLE_LVL;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.out;

endmodule

// File: rtl/lsens_regs.sv
module lsens_regs
    import lsens_pkg::*;
#(
    parameter logic [2:0] ID_CODE = 3'b101,
    parameter int         DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [7:0]        rd_addr_i,
    output logic [7:0]        rd_data_o,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              sample_vld_i,
    output logic [2:0]        mode_o,
    output logic [1:0]        res_o,
    output logic [1:0]        range_o
);
    typedef struct packed {
        logic [2:0]        mode;
        logic [1:0]        res;
        logic [1:0]        rng;
        logic [DATA_W-1:0] dat;
        logic              bout;
    } regs_t;

    regs_t q, d;
    logic  unused_wbit4;

    assign unused_wbit4 = wr_data_i[4];

    always_comb begin
        d = q;
        if (sample_vld_i) begin
            d.dat = sample_i;
        end
        if (wr_en_i) begin
            case (wr_addr_i)
                A_MODE: d.mode = wr_data_i[7:5];
                A_CTRL: {d.res, d.rng} = wr_data_i[3:0];
                A_IDST: if (!wr_data_i[7]) d.bout = 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr_i)
            A_MODE:  rd_data_o = {q.mode, 5'b0};
            A_CTRL:  rd_data_o = {4'b0, q.res, q.rng};
            A_DLO:   rd_data_o = q.dat[7:0];
            A_DHI:   rd_data_o = q.dat[15:8];
            A_IDST:  rd_data_o = {q.bout, 1'b0, ID_CODE, 3'b000};
            default: rd_data_o = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.bout <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mode_o  = q.mode;
    assign res_o   = q.res;
    assign range_o = q.rng;

    AST_BOUT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(q.bout)); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sample_vld_i) |-> $stable(q.dat)); // R4
    AST_MODE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mode) |-> $past(wr_en_i && (wr_addr_i == A_MODE))); // R3

endmodule

// File: rtl/lsens_i2c_engine.sv
module lsens_i2c_engine
    import lsens_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic [7:0] rd_addr_o,
    input  logic [7:0] rd_data_i
);
    typedef struct packed {
        xfer_st_e   st;
        rx_ph_e     ph;
        logic [3:0] cnt;
        logic [7:0] sr;
        logic [7:0] ptr;
        logic       oe;
        logic       hnak;
        logic       scl_p;
        logic       sda_p;
    } eng_t;

    eng_t q, d;
    logic scl_rise, scl_fall, start_evt, stop_evt, wr_en;

    assign scl_rise  = scl_i & ~q.scl_p;
    assign scl_fall  = ~scl_i & q.scl_p;
    assign start_evt = scl_i & q.scl_p & q.sda_p & ~sda_i;
    assign stop_evt  = scl_i & q.scl_p & ~q.sda_p & sda_i;

    always_comb begin
        d       = q;
        d.scl_p = scl_i;
        d.sda_p = sda_i;
        wr_en   = 1'b0;
        if (stop_evt) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_evt) begin
            d.st  = ST_RX;
            d.ph  = PH_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sr  = {q.sr[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        if (q.ph == PH_DEV && q.sr[7:1] != DEV_ADDR) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st = ST_ACK;
                            d.oe = 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe = 1'b0;
                        d.st = ST_RX;
                        case (q.ph)
                            PH_DEV: begin
                                if (q.sr[0]) begin
                                    d.st = ST_TX;
                                    d.sr = rd_data_i;
                                    d.oe = ~rd_data_i[7];
                                end else begin
                                    d.ph = PH_REG;
                                end
                            end
                            PH_REG: begin
                                d.ptr = q.sr;
                                d.ph  = PH_WR;
                            end
                            default: begin
                                wr_en = 1'b1;
                                d.ptr = ptr_next(q.ptr);
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.cnt = '0;
                            d.oe  = 1'b0;
                            d.st  = ST_HACK;
                        end else begin
                            d.sr = {q.sr[6:0], 1'b0};
                            d.oe = ~q.sr[6];
                        end
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        d.hnak = sda_i;
                    end else if (scl_fall) begin
                        d.ptr = ptr_next(q.ptr);
                        if (!q.hnak) begin
                            d.st = ST_TX;
                            d.sr = rd_data_i;
                            d.oe = ~rd_data_i[7];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ph    <= PH_DEV;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign wr_en_o   = wr_en;
    assign wr_addr_o = q.ptr;
    assign wr_data_o = q.sr;
    assign rd_addr_o = (q.st == ST_HACK) ? ptr_next(q.ptr) : q.ptr;

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(q.oe) && !$past(start_evt || stop_evt)) |-> !scl_i); // R10
    AST_WR_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (q.oe && !scl_i)); // R9

endmodule

// File: rtl/lightsense_i2c_target.sv
module lightsense_i2c_target #(
    parameter logic [6:0] DEV_ADDR   = 7'b1000100,
    parameter logic [2:0] ID_CODE    = 3'b101,
    parameter int         SYNC_DEPTH = 2,
    parameter int         VOTES      = 3,
    parameter int         DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              sample_vld_i,
    output logic [2:0]        mode_o,
    output logic [1:0]        res_o,
    output logic [1:0]        range_o
);
    logic       scl_f, sda_f;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    lsens_line_filter #(.SYNC_DEPTH(SYNC_DEPTH), .VOTES(VOTES), .IDLE_LVL(1'b1)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f)
    );

    lsens_line_filter #(.SYNC_DEPTH(SYNC_DEPTH), .VOTES(VOTES), .IDLE_LVL(1'b1)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f)
    );

    lsens_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
        .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    lsens_regs #(.ID_CODE(ID_CODE), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .sample_i(sample_i), .sample_vld_i(sample_vld_i),
        .mode_o(mode_o), .res_o(res_o), .range_o(range_o)
    );

endmodule

// File: tb/test_lightsense_i2c_target.sv
module test_lightsense_i2c_target;

    localparam int CLK_PERIOD = 10;
    localparam int QT         = 8;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic [15:0] sample = 16'h0;
    logic        sample_vld = 1'b0;
    wire         sda_oe;
    wire  [2:0]  mode;
    wire  [1:0]  res, rng;
    wire         sda_line = ~(m_low | sda_oe);

    int total = 0;
    int bad = 0;
    int viol = 0;
    bit done = 0;
    logic oe_prev = 1'b0;

    logic [2:0]  e_mode = 3'd0;
    logic [1:0]  e_res = 2'd0, e_rng = 2'd0;
    logic [15:0] e_dat = 16'h0;
    logic        e_bout = 1'b1;
    logic [7:0]  wbuf [8];
    logic [7:0]  rbuf [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    lightsense_i2c_target i_lightsense_i2c_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .sample_i(sample), .sample_vld_i(sample_vld),
        .mode_o(mode), .res_o(res), .range_o(rng)
    );

    // R10 monitor: drive enable may only move while the bus clock is low
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl) viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mdl_nxt(input logic [7:0] p);
        if (p < 8'h03) return p + 8'd1;
        if (p < 8'h0F) return 8'h0F;
        return 8'h00;
    endfunction

    function automatic logic [7:0] mdl_rd(input logic [7:0] a);
        case (a)
            8'h00:   return {e_mode, 5'b0};
            8'h01:   return {4'b0, e_res, e_rng};
            8'h02:   return e_dat[7:0];
            8'h03:   return e_dat[15:8];
            8'h0F:   return {e_bout, 1'b0, 3'b101, 3'b000};
            default: return 8'h00;
        endcase
    endfunction

    task automatic mdl_wr(input logic [7:0] a, input logic [7:0] v);
        case (a)
            8'h00: e_mode = v[7:5];
            8'h01: {e_res, e_rng} = v[3:0];
            8'h0F: if (!v[7]) e_bout = 1'b0;
            default: ;
        endcase
    endtask

    task automatic qwait(input int n = 1);
        repeat (n * QT) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; qwait();
        scl = 1'b1;   qwait();
        m_low = 1'b1; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qwait();
        scl = 1'b1;   qwait();
        m_low = 1'b0; qwait(2);
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        m_low = ~b; qwait();
        scl = 1'b1; qwait();
        if (glitch) begin
            @(negedge clk) scl = 1'b0;
            @(negedge clk) scl = 1'b1;
        end
        qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic put_byte(input logic [7:0] b, input int glitch_bit, output logic acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i], i == glitch_bit);
        m_low = 1'b0; qwait();
        scl = 1'b1;   qwait();
        acked = (sda_line == 1'b0);
        qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic get_byte(input bit ack, output logic [7:0] b);
        m_low = 1'b0;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            qwait();
            scl = 1'b1; qwait();
            b = {b[6:0], sda_line};
            qwait();
            scl = 1'b0; qwait();
        end
        put_bit(!ack, 1'b0);
    endtask

    task automatic write_tx(input logic [7:0] ra, input int n, input int glitch_bit);
        logic a;
        logic [7:0] p;
        bus_start();
        put_byte(8'h88, -1, a);  chk("R1 write address ack", a, 1);
        put_byte(ra, -1, a);     chk("R2 register address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], (i == 0) ? glitch_bit : -1, a);
            chk("R2 data byte ack", a, 1);
        end
        bus_stop();
        p = ra;
        for (int i = 0; i < n; i++) begin
            mdl_wr(p, wbuf[i]);
            p = mdl_nxt(p);
        end
    endtask

    task automatic read_tx(input logic [7:0] ra, input int n, input string tag);
        logic a;
        logic [7:0] p;
        bus_start();
        put_byte(8'h88, -1, a);  chk("R1 write address ack", a, 1);
        put_byte(ra, -1, a);     chk("R2 register address ack", a, 1);
        bus_start();
        put_byte(8'h89, -1, a);  chk("R1 R8 read address ack", a, 1);
        for (int i = 0; i < n; i++) get_byte(i != n - 1, rbuf[i]);
        bus_stop();
        chk("R8 SDA released after NACK", sda_oe, 0);
        p = ra;
        for (int i = 0; i < n; i++) begin
            chk(tag, rbuf[i], mdl_rd(p));
            p = mdl_nxt(p);
        end
    endtask

    task automatic load_sample(input logic [15:0] v);
        @(negedge clk);
        sample = v; sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
        e_dat = v;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic a;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R6 reset state at the ports and through the bus
        chk("R6 sda released", sda_oe, 0);
        chk("R6 mode", mode, 0);
        chk("R6 resolution", res, 0);
        chk("R6 range", rng, 0);
        read_tx(8'h00, 5, "R6 R7 reset values in pointer order");

        // R3 near-exhaustive sweep of the command fields
        for (int k = 0; k < 16; k++) begin
            wbuf[0] = 8'((k * 37 + 11) & 255);
            wbuf[1] = 8'((k * 73 + 5) & 255);
            write_tx(8'h00, 2, -1);
            chk("R3 mode port", mode, e_mode);
            chk("R3 resolution port", res, e_res);
            chk("R3 range port", rng, e_rng);
            read_tx(8'h00, 2, "R3 command readback");
        end

        // R4 data registers from the sideband, writes ignored but acked
        load_sample(16'hA55A);
        read_tx(8'h02, 2, "R4 data low/high");
        wbuf[0] = 8'h12; wbuf[1] = 8'h34;
        write_tx(8'h02, 2, -1);
        read_tx(8'h02, 2, "R4 data unchanged by write");
        load_sample(16'h0F3C);
        read_tx(8'h03, 1, "R4 single read high");
        read_tx(8'h02, 1, "R4 single read low");

        // R5 writing 1 keeps the flag, wrap write clears it
        wbuf[0] = 8'hFF;
        write_tx(8'h0F, 1, -1);
        read_tx(8'h0F, 1, "R5 flag survives write of 1");
        wbuf[0] = 8'h77; wbuf[1] = 8'h7F; wbuf[2] = 8'hE0;
        write_tx(8'h03, 3, -1);
        chk("R7 wrap write reached 0x00", mode, 3'd7);
        read_tx(8'h0F, 3, "R5 R7 flag cleared and wrap read");
        wbuf[0] = 8'hFF;
        write_tx(8'h0F, 1, -1);
        read_tx(8'h0F, 1, "R5 flag not set by host");

        // R7 unimplemented addresses
        read_tx(8'h07, 2, "R7 gap address reads 0 then 0x0F");
        read_tx(8'h20, 2, "R7 high address reads 0 then 0x00");

        // R1 non-matching address ignored until START
        bus_start();
        put_byte(8'h8A, -1, a); chk("R1 wrong address NACK", a, 0);
        put_byte(8'h00, -1, a); chk("R1 idle after mismatch", a, 0);
        put_byte(8'h00, -1, a); chk("R1 idle after mismatch data", a, 0);
        bus_stop();
        chk("R1 mode untouched by mismatch", mode, e_mode);

        // R9 STOP inside a data byte
        bus_start();
        put_byte(8'h88, -1, a);
        put_byte(8'h00, -1, a);
        for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
        bus_stop();
        chk("R9 abort after 4 bits", mode, e_mode);
        bus_start();
        put_byte(8'h88, -1, a);
        put_byte(8'h01, -1, a);
        for (int i = 0; i < 7; i++) put_bit(1'b0, 1'b0);
        bus_stop();
        chk("R9 abort after 7 bits res", res, e_res);
        chk("R9 abort after 7 bits range", rng, e_rng);
        read_tx(8'h00, 2, "R9 registers unchanged after abort");

        // R11 one-cycle SCL dropout inside a data bit
        wbuf[0] = 8'h0A;
        write_tx(8'h01, 1, 5);
        chk("R11 glitch rejected res", res, 2'd2);
        chk("R11 glitch rejected range", rng, 2'd2);

        chk("R10 SDA enable moved only with SCL low", viol, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule